// File: doc/BRIEF.md
# SPI Slave Frame Capture Queue

This block takes frames of variable length from a four-wire SPI slave port (mode 0: idle-low clock, data sampled on the rising clock edge) and keeps them in a short queue. A serializer further down the chain pulls them out. A frame is every bit clocked in while chip select is held low. All SPI inputs are brought into the system clock domain through a chain of synchronizer flops. The serial clock is then oversampled, so the system clock must run at least four times faster than SCK. With the default two stages that means at least 40 MHz for a 10 MHz SCK.

The block does not look at frame content. It checks only the bit count. It also samples a transmit-enable input once, on the cycle chip select is seen to fall, and that value decides whether the frame may enter the queue. The consumer sees the oldest stored frame on a valid/ready pair. The frame bits are left-justified in a 64-bit word, and a separate field gives the bit count. When the queue is full, a new accepted frame replaces the newest stored entry, so the older entries that are waiting still go out in order.

Top module: `spi_frame_queue`

## Requirements
- R1: After reset the queue is empty: `out_valid` is low and `out_data`/`out_len` read zero.
- R2: A frame of 8 to 64 bits, inclusive, is stored, and `out_len` reports exactly the number of rising SCK edges seen while `cs_n` was low.
- R3: A frame with fewer than 8 edges (including zero) or more than 64 edges is discarded and the queue contents do not change.
- R4: The first bit received lands in `out_data[63]` and later bits fill downwards. Bit positions below the frame length read zero.
- R5: `tx_en` is sampled when `cs_n` falls. If it is low then, the frame is discarded even if `tx_en` rises during the frame. If it is high then, the frame is kept even if `tx_en` falls during the frame.
- R6: Up to 3 frames are held in arrival order, and entries of different lengths may be present together.
- R7: With 3 frames held, an accepted frame overwrites the most recently stored entry. The two older entries are untouched. A discarded frame leaves a full queue unchanged.
- R8: The head entry is removed on a clock where `out_valid` and `out_ready` are both high. Otherwise `out_valid`, `out_data` and `out_len` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| sdi | input | 1 | SPI serial data in, sampled on rising SCK |
| cs_n | input | 1 | Active-low chip select delimiting a frame |
| tx_en | input | 1 | Transmit enable, sampled at frame start |
| out_valid | output | 1 | Head entry present |
| out_data | output | 64 | Head frame bits, left-justified |
| out_len | output | 7 | Head frame bit count (8..64) |
| out_ready | input | 1 | Consumer takes the head entry |

## Verification
A wrong bit counter shows up at the output within a few clocks of chip select rising. Either a frame is stored with the wrong `out_len`, or a frame at a length boundary (7, 8, 64, 65) is accepted or dropped on the wrong side. A wrong write index or a missing zero clear shows up in the same window as a shifted or dirty `out_data`. Broken queue pointers or occupancy show up only later, when the consumer pops. The heads then arrive out of order, an overwrite on a full queue hits an older entry, or `out_valid` stays high or drops too early. For that reason the bench drains every fill it makes and compares each head it pops.

// File: rtl/spifq_pkg.sv
package spifq_pkg;
   localparam int unsigned DEF_MAX_BITS = 64;
   localparam int unsigned DEF_MIN_BITS = 8;
   localparam int unsigned DEF_DEPTH    = 3;
   localparam int unsigned DEF_SYNC     = 2;

   // capture state of the frame being received
   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_KEEP = 2'd1,
      CAP_SKIP = 2'd2
   } cap_state_e;
endpackage

// File: rtl/spifq_sync.sv
module spifq_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/spifq_capture.sv
module spifq_capture
   import spifq_pkg::*;
#(
   parameter int unsigned MAX_BITS = DEF_MAX_BITS,
   parameter int unsigned MIN_BITS = DEF_MIN_BITS,
   localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1),
   localparam int unsigned CNT_W   = $clog2(MAX_BITS + 2),
   localparam int unsigned IDX_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sck_s,
   input  logic                sdi_s,
   input  logic                cs_n_s,
   input  logic                txen_s,
   output logic                push,
   output logic [MAX_BITS-1:0] push_data,
   output logic [LEN_W-1:0]    push_len
);
   cap_state_e          state;
   logic                sck_q, cs_q;
   logic [CNT_W-1:0]    cnt;
   logic [MAX_BITS-1:0] shreg;
   logic [IDX_W-1:0]    wr_idx;

   wire sck_rise = sck_s & ~sck_q;
   wire cs_fall  = cs_q & ~cs_n_s;
   wire cs_rise  = ~cs_q & cs_n_s;
   wire len_ok   = (cnt >= CNT_W'(MIN_BITS)) && (cnt <= CNT_W'(MAX_BITS));

   assign wr_idx = IDX_W'(MAX_BITS - 1) - cnt[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CAP_IDLE;
         cnt   <= '0;
         shreg <= '0;
      end else if (cs_fall) begin
         state <= txen_s ? CAP_KEEP : CAP_SKIP;
         cnt   <= '0;
         shreg <= '0;
      end else if (state != CAP_IDLE) begin
         if (cs_rise) begin
            state <= CAP_IDLE;
         end else if (sck_rise) begin
            if (cnt < CNT_W'(MAX_BITS)) shreg[wr_idx] <= sdi_s;
            if (cnt <= CNT_W'(MAX_BITS)) cnt <= cnt + 1'b1;
         end
      end
   end

   assign push      = (state == CAP_KEEP) && cs_rise && len_ok;
   assign push_data = shreg;
   assign push_len  = LEN_W'(cnt);
endmodule

// File: rtl/spifq_store.sv
module spifq_store #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned LEN_W  = 7,
   parameter int unsigned DEPTH  = 3,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [LEN_W-1:0]  push_len,
   input  logic              pop_req,
   output logic              head_valid,
   output logic [DATA_W-1:0] head_data,
   output logic [LEN_W-1:0]  head_len
);
   logic [DATA_W-1:0] mem_d [DEPTH];
   logic [LEN_W-1:0]  mem_l [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [OCC_W-1:0]  occ;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   function automatic logic [PTR_W-1:0] prv(input logic [PTR_W-1:0] p);
      return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
   endfunction

   wire pop    = pop_req && (occ != '0);
   wire full   = (occ == OCC_W'(DEPTH));
   wire room   = !full || pop;
   wire append = push && room;
   wire [PTR_W-1:0] tgt = room ? wr_ptr : prv(wr_ptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] <= '0;
            mem_l[i] <= '0;
         end
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push) begin
            mem_d[tgt] <= push_data;
            mem_l[tgt] <= push_len;
         end
         if (append) wr_ptr <= nxt(wr_ptr);
         if (pop)    rd_ptr <= nxt(rd_ptr);
         occ <= occ + OCC_W'(append) - OCC_W'(pop);
      end
   end

   assign head_valid = (occ != '0);
   assign head_data  = mem_d[rd_ptr];
   assign head_len   = mem_l[rd_ptr];
endmodule

// File: rtl/spi_frame_queue.sv
module spi_frame_queue
   import spifq_pkg::*;
#(
   parameter int unsigned MAX_BITS    = DEF_MAX_BITS,
   parameter int unsigned MIN_BITS    = DEF_MIN_BITS,
   parameter int unsigned DEPTH       = DEF_DEPTH,
   parameter int unsigned SYNC_STAGES = DEF_SYNC,
   localparam int unsigned LEN_W      = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sck,
   input  logic                sdi,
   input  logic                cs_n,
   input  logic                tx_en,
   output logic                out_valid,
   output logic [MAX_BITS-1:0] out_data,
   output logic [LEN_W-1:0]    out_len,
   input  logic                out_ready
);
   if (MIN_BITS < 1 || MIN_BITS > MAX_BITS) begin : g_bad_len
      $error("spi_frame_queue: MIN_BITS must be in 1..MAX_BITS");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("spi_frame_queue: DEPTH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_frame_queue: SYNC_STAGES must be at least 2");
   end

   // bit order: {tx_en, cs_n, sdi, sck}
   logic [3:0] pins_s;
   logic                push;
   logic [MAX_BITS-1:0] push_data;
   logic [LEN_W-1:0]    push_len;

   spifq_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (4),
      .RST_VAL(4'b0100)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({tx_en, cs_n, sdi, sck}),
      .dout (pins_s)
   );

   spifq_capture #(
      .MAX_BITS(MAX_BITS),
      .MIN_BITS(MIN_BITS)
   ) i_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (pins_s[0]),
      .sdi_s    (pins_s[1]),
      .cs_n_s   (pins_s[2]),
      .txen_s   (pins_s[3]),
      .push     (push),
      .push_data(push_data),
      .push_len (push_len)
   );

   spifq_store #(
      .DATA_W(MAX_BITS),
      .LEN_W (LEN_W),
      .DEPTH (DEPTH)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .push_len  (push_len),
      .pop_req   (out_ready),
      .head_valid(out_valid),
      .head_data (out_data),
      .head_len  (out_len)
   );
endmodule

// File: rtl/spifq_chk.sv
module spifq_chk #(
   parameter int unsigned MAX_BITS = 64,
   parameter int unsigned MIN_BITS = 8,
   parameter int unsigned DEPTH    = 3,
   parameter int unsigned LEN_W    = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n,
   input logic                out_valid,
   input logic [MAX_BITS-1:0] out_data,
   input logic [LEN_W-1:0]    out_len,
   input logic                out_ready
);
   // R2
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len >= LEN_W'(MIN_BITS)) && (out_len <= LEN_W'(MAX_BITS)));

   // R2
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(cs_n));

   // R4
   left_just_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data << out_len) == '0));

   // R8
   hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid);

   if (DEPTH > 1) begin : g_hold_data
      // R8
      hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && !out_ready |=> $stable(out_data) && $stable(out_len));
   end
endmodule

bind spi_frame_queue spifq_chk #(
   .MAX_BITS(MAX_BITS),
   .MIN_BITS(MIN_BITS),
   .DEPTH   (DEPTH),
   .LEN_W   (LEN_W)
) i_spifq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .out_valid(out_valid),
   .out_data (out_data),
   .out_len  (out_len),
   .out_ready(out_ready)
);

// File: tb/test_spi_frame_queue.sv
module test_spi_frame_queue;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic        cs_n = 1'b1;
   logic        tx_en = 1'b0;
   logic        out_ready = 1'b0;
   logic        out_valid;
   logic [63:0] out_data;
   logic [6:0]  out_len;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spi_frame_queue i_spi_frame_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck      (sck),
      .sdi      (sdi),
      .cs_n     (cs_n),
      .tx_en    (tx_en),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_len  (out_len),
      .out_ready(out_ready)
   );

   function automatic logic [63:0] pat_of(input int l, input int salt);
      return {32'h9E37_79B9 ^ 32'(l * 7 + salt), 32'hC2B2_AE35 + 32'(l * 4951 + salt)};
   endfunction

   function automatic logic [63:0] top_mask(input int l);
      return ~(64'hFFFF_FFFF_FFFF_FFFF >> l);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // sends nbits bits; tx_en flips before bit number flip_at (negative: never)
   task automatic send(input int nbits, input logic [63:0] bits, input logic en, input int flip_at);
      tx_en = en;
      tick(4);
      cs_n = 1'b0;
      tick(6);
      for (int i = 0; i < nbits; i++) begin
         if (i == flip_at) tx_en = ~tx_en;
         sdi = (i < 64) ? bits[63 - i] : i[0];
         tick(5);
         sck = 1'b1;
         tick(5);
         sck = 1'b0;
      end
      tick(5);
      cs_n = 1'b1;
      tick(8);
   endtask

   task automatic head(input string req, input logic [63:0] d, input int l);
      chk(req, {63'd0, out_valid}, 64'd1);
      chk(req, out_data, d);
      chk(req, {57'd0, out_len}, 64'(l));
   endtask

   task automatic pop();
      out_ready = 1'b1;
      tick(1);
      out_ready = 1'b0;
   endtask

   initial begin
      tick(3);
      // R1
      chk("R1", {63'd0, out_valid}, 64'd0);
      chk("R1", out_data, 64'd0);
      chk("R1", {57'd0, out_len}, 64'd0);
      rst_n = 1'b1;
      tick(3);

      // R2 R3 R4: length sweep, each frame alone
      for (int l = 0; l <= 70; l++) begin
         logic [63:0] p;
         p = pat_of(l, 3);
         send(l, p, 1'b1, -1);
         if (l >= 8 && l <= 64) begin
            head("R2_R4", p & top_mask(l), l);
            pop();
            chk("R8", {63'd0, out_valid}, 64'd0);
         end else begin
            chk("R3", {63'd0, out_valid}, 64'd0);
         end
      end

      // R4: extreme contents are stored untouched
      send(64, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, -1);
      head("R4", 64'hFFFF_FFFF_FFFF_FFFF, 64);
      pop();
      send(9, 64'd0, 1'b1, -1);
      head("R4", 64'd0, 9);
      pop();

      // R5: enable low at start, raised mid-frame -> dropped
      send(16, pat_of(16, 11), 1'b0, 4);
      chk("R5", {63'd0, out_valid}, 64'd0);
      // R5: enable high at start, dropped mid-frame -> kept
      send(20, pat_of(20, 12), 1'b1, 5);
      head("R5", pat_of(20, 12) & top_mask(20), 20);
      pop();
      tx_en = 1'b1;

      // R6 R7 R8: fill, hold, overwrite newest, drain in order
      send(8,  pat_of(8, 21),  1'b1, -1);
      send(33, pat_of(33, 22), 1'b1, -1);
      send(64, pat_of(64, 23), 1'b1, -1);
      head("R6", pat_of(8, 21) & top_mask(8), 8);
      tick(20);
      head("R8", pat_of(8, 21) & top_mask(8), 8);
      send(12, pat_of(12, 24), 1'b1, -1);
      send(40, pat_of(40, 25), 1'b0, -1);
      send(5,  pat_of(5, 26),  1'b1, -1);
      head("R7", pat_of(8, 21) & top_mask(8), 8);
      pop();
      head("R6", pat_of(33, 22) & top_mask(33), 33);
      pop();
      head("R7", pat_of(12, 24) & top_mask(12), 12);
      pop();
      chk("R8", {63'd0, out_valid}, 64'd0);

      // R6: freed slot reused after partial drain
      send(10, pat_of(10, 31), 1'b1, -1);
      send(50, pat_of(50, 32), 1'b1, -1);
      pop();
      send(27, pat_of(27, 33), 1'b1, -1);
      head("R6", pat_of(50, 32) & top_mask(50), 50);
      pop();
      head("R6", pat_of(27, 33) & top_mask(27), 27);
      pop();
      chk("R6", {63'd0, out_valid}, 64'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule